// File: doc/BRIEF.md
# Tagged Geometric-History Branch Direction Predictor

This block guesses the direction of conditional branches for a processor front end. A lookup presents a branch address. One cycle later the block returns a taken or not-taken guess, along with metadata. The metadata names which table supplied the guess and what the next-best table would have said. The guess comes from the longest-history tagged table whose stored tag matches. If no tagged table matches, an untagged table of 2-bit counters indexed by address alone supplies the guess.

When the branch resolves, the front end replays the address, the real outcome and the metadata it received on a separate update port. The block then does four things:
- it trains the counter of the table that supplied the guess;
- it adjusts that entry's usefulness;
- on a wrong guess, it claims an entry in a longer-history table;
- it shifts the outcome into the global history register.

The four tagged tables use 5, 13, 30 and 71 bits of that history.

Top module: `tage_predictor`

## Requirements
- R1: After reset every tagged entry is invalid and all usefulness counters are 0. Every base counter holds 01 and the global history is all zeros, so the first lookup of any address yields not-taken with provider code 0.
- R2: `pred_valid` is high exactly in the cycle after a cycle with `req_valid` high. `pred_taken`, `pred_provider` and `pred_alt_taken` reflect the table state and history present in the request cycle.
- R3: Every direction counter is 2 bits: 00 strong not-taken, 01 weak not-taken, 10 weak taken, 11 strong taken. A counter predicts taken when its upper bit is 1.
- R4: Training moves a counter one step toward the outcome and saturates at 00 and 11. From 11, two not-taken outcomes are needed before the guess flips.
- R5: The base table has 64 entries indexed by pc[7:2]. It has no tag.
- R6: Each update with `upd_valid` high shifts the history left by one bit and places the outcome (1 taken, 0 not-taken) at bit 0. Tagged tables k=1..4 see history bits [4:0], [12:0], [29:0] and [70:0] respectively.
- R7: Tagged table k has 32 entries. Each entry holds an 8-bit tag, a direction counter and a 2-bit usefulness counter. The index is pc[6:2] XOR F5 and the tag is pc[14:7] XOR F8. Fw is the XOR of the table's history slice cut into w-bit chunks starting at bit 0, with the last chunk zero-padded.
- R8: A table hits when its indexed entry is valid and its tag matches. The provider is the hitting table with the highest k, reported as code k; code 0 means the base table. The alternate guess comes from the next lower hitting table, or from the base table if there is none.
- R9: An update trains only the counter of the reported provider, at the index recomputed from the update address and the current history.
- R10: When the provider is tagged and its guess differed from the alternate, its usefulness counter rises by 1 if the guess was right and falls by 1 if it was wrong, saturating at 0 and 3.
- R11: On a wrong guess with provider code below 4, the block looks at the tables with k greater than the provider. Among those, the lowest-k table whose indexed usefulness is 0 is overwritten: entry valid, computed tag, counter 10 if taken or 01 if not, usefulness 0.
- R12: On a wrong guess where no longer table has usefulness 0, every longer table's indexed usefulness counter is decremented instead.
- R13: No entry is allocated when the guess was correct or when the provider is table 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Lookup request strobe |
| req_pc | input | 32 | Branch address to look up |
| pred_valid | output | 1 | Lookup result valid (one cycle after request) |
| pred_taken | output | 1 | Predicted direction |
| pred_provider | output | 3 | Providing table code, 0 = base |
| pred_alt_taken | output | 1 | Alternate direction |
| upd_valid | input | 1 | Resolved-branch update strobe |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_taken | input | 1 | Resolved direction |
| upd_pred_taken | input | 1 | Direction that was predicted |
| upd_provider | input | 3 | Provider code returned by the lookup |
| upd_alt_taken | input | 1 | Alternate direction returned by the lookup |

## Verification
A behavioural model holds the tables as plain arrays and computes the hashes chunk by chunk. Its outputs are compared with every lookup result, and `pred_valid` is checked every cycle.

The stimulus uses several input patterns:
- A single fresh address and a biased branch that flips direction exercise the reset state and counter saturation.
- Two addresses that share a base entry but differ in their tags show whether the tag check separates them.
- An alternating branch and a period-seven loop branch can only be learned through history, so they show whether the longer tables are indexed, tagged and chosen correctly.
- A pseudo-random mix over eight addresses fills the tables. This drives the usefulness decay path and the choice of allocation target.

// File: rtl/tage_pkg.sv
// Shared sizes and helpers for the tagged geometric-history predictor.
// Assumes word-aligned branch addresses (the low PC_LSB bits carry no information).
package tage_pkg;
    localparam int NUM_TAB = 4;
    localparam int PC_W    = 32;
    localparam int PC_LSB  = 2;
    localparam int BASE_IW = 6;
    localparam int TAB_IW  = 5;
    localparam int TAG_W   = 8;
    localparam int HIST_LEN [NUM_TAB] = '{5, 13, 30, 71};
    localparam int HIST_W  = 71;
    localparam int PROV_W  = $clog2(NUM_TAB + 1);

    // One saturating step of a 2-bit counter toward the outcome.
    function automatic logic [1:0] ctr_step(logic [1:0] c, logic up);
        if (up) return (c == 2'b11) ? c : c + 2'b01;
        else    return (c == 2'b00) ? c : c - 2'b01;
    endfunction
endpackage

// File: rtl/tage_hash.sv
// Computes a tagged table's index and partial tag from a PC and the global
// history. The history slice of length LEN is XOR-folded into IW bits for the
// index and TW bits for the tag, each folded value XORed with distinct PC bits.
// Assumes LEN <= HIST_W.
module tage_hash #(
    parameter int PC_W   = 32,
    parameter int PC_LSB = 2,
    parameter int HIST_W = 71,
    parameter int LEN    = 5,
    parameter int IW     = 5,
    parameter int TW     = 8
) (
    input  logic [PC_W-1:0]   pc,
    input  logic [HIST_W-1:0] ghist,
    output logic [IW-1:0]     idx,
    output logic [TW-1:0]     tag
);
    logic [IW-1:0] idx_fold;
    logic [TW-1:0] tag_fold;
    logic          unused_bits;

    // Fold the history slice into both widths, bit by bit.
    always_comb begin
        idx_fold = '0;
        tag_fold = '0;
        for (int i = 0; i < LEN; i++) begin
            idx_fold[i % IW] = idx_fold[i % IW] ^ ghist[i];
            tag_fold[i % TW] = tag_fold[i % TW] ^ ghist[i];
        end
    end

    assign idx = pc[PC_LSB +: IW] ^ idx_fold;
    assign tag = pc[PC_LSB + IW +: TW] ^ tag_fold;
    assign unused_bits = ^{pc, ghist};
endmodule

// File: rtl/tage_base_table.sv
// Untagged bimodal table of 2-bit counters indexed by PC bits alone.
// Read is combinational; training happens on the clock edge.
module tage_base_table
    import tage_pkg::*;
#(
    parameter int IW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] rd_idx,
    output logic          rd_dir,
    input  logic [IW-1:0] wr_idx,
    input  logic          ctr_en,
    input  logic          taken
);
    localparam int DEPTH = 1 << IW;
    logic [1:0] ctr_q [DEPTH];

    // Reset to weak not-taken; train one step on each enabled update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) ctr_q[i] <= 2'b01;
        end else if (ctr_en) begin
            ctr_q[wr_idx] <= ctr_step(ctr_q[wr_idx], taken);
        end
    end

    assign rd_dir = ctr_q[rd_idx][1];

    assert_base_sat_hi_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctr_en && taken && ctr_q[wr_idx] == 2'b11) |=> ctr_q[$past(wr_idx)] == 2'b11);
    assert_base_sat_lo_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctr_en && !taken && ctr_q[wr_idx] == 2'b00) |=> ctr_q[$past(wr_idx)] == 2'b00);
endmodule

// File: rtl/tage_tagged_table.sv
// One tagged table: valid bit, partial tag, direction counter and usefulness
// counter per entry. Lookup read is combinational. The update side exposes
// the usefulness at the update index and applies training, usefulness change
// or allocation on the edge. Allocation takes precedence over other writes.
module tage_tagged_table
    import tage_pkg::*;
#(
    parameter int IW = 5,
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] rd_idx,
    input  logic [TW-1:0] rd_tag,
    output logic          rd_hit,
    output logic          rd_dir,
    input  logic [IW-1:0] wr_idx,
    input  logic [TW-1:0] wr_tag,
    output logic [1:0]    wr_u,
    input  logic          ctr_en,
    input  logic          taken,
    input  logic          u_inc,
    input  logic          u_dec,
    input  logic          alloc
);
    localparam int DEPTH = 1 << IW;
    logic [DEPTH-1:0] valid_q;
    logic [TW-1:0]    tag_q [DEPTH];
    logic [1:0]       ctr_q [DEPTH];
    logic [1:0]       u_q   [DEPTH];

    // Entry state: clear on reset, then allocate or train on updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                tag_q[i] <= '0;
                ctr_q[i] <= 2'b01;
                u_q[i]   <= 2'b00;
            end
        end else if (alloc) begin
            valid_q[wr_idx] <= 1'b1;
            tag_q[wr_idx]   <= wr_tag;
            ctr_q[wr_idx]   <= taken ? 2'b10 : 2'b01;
            u_q[wr_idx]     <= 2'b00;
        end else begin
            if (ctr_en) ctr_q[wr_idx] <= ctr_step(ctr_q[wr_idx], taken);
            if (u_inc && u_q[wr_idx] != 2'b11)      u_q[wr_idx] <= u_q[wr_idx] + 2'b01;
            else if (u_dec && u_q[wr_idx] != 2'b00) u_q[wr_idx] <= u_q[wr_idx] - 2'b01;
        end
    end

    assign rd_hit = valid_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
    assign rd_dir = ctr_q[rd_idx][1];
    assign wr_u   = u_q[wr_idx];

    assert_tag_ctr_sat_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctr_en && !alloc && taken && ctr_q[wr_idx] == 2'b11) |=> ctr_q[$past(wr_idx)] == 2'b11);
    assert_u_sat_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (u_inc && !alloc && u_q[wr_idx] == 2'b11) |=> u_q[$past(wr_idx)] == 2'b11);
    assert_alloc_init_R11: assert property (@(posedge clk) disable iff (!rst_n)
        alloc |=> (valid_q[$past(wr_idx)] && u_q[$past(wr_idx)] == 2'b00
                   && tag_q[$past(wr_idx)] == $past(wr_tag)
                   && ctr_q[$past(wr_idx)] == ($past(taken) ? 2'b10 : 2'b01)));
endmodule

// File: rtl/tage_predictor.sv
// Top of the direction predictor. Lookup: hashes the request PC against each
// tagged table, selects the longest hitting table (base table underneath) and
// registers the guess plus provider and alternate. Update: recomputes hashes
// from the update PC and the current history, trains the provider, adjusts
// usefulness, allocates on a wrong guess and shifts the history.
// Assumes updates arrive in program order, so history at update time equals
// history at lookup time.
module tage_predictor
    import tage_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [PC_W-1:0]   req_pc,
    output logic              pred_valid,
    output logic              pred_taken,
    output logic [PROV_W-1:0] pred_provider,
    output logic              pred_alt_taken,
    input  logic              upd_valid,
    input  logic [PC_W-1:0]   upd_pc,
    input  logic              upd_taken,
    input  logic              upd_pred_taken,
    input  logic [PROV_W-1:0] upd_provider,
    input  logic              upd_alt_taken
);
    logic [HIST_W-1:0]       ghist_q;
    logic [NUM_TAB-1:0]      lk_hit, lk_dir;
    logic [NUM_TAB-1:0]      cand, up_free, alloc_vec, ctr_en, u_inc, u_dec;
    logic [NUM_TAB-1:0][1:0] up_u;
    logic                    base_dir, mispred, differ;
    logic                    sel_dir, sel_alt;
    logic [PROV_W-1:0]       sel_prov;

    assign mispred   = upd_valid && (upd_pred_taken != upd_taken);
    assign differ    = upd_pred_taken != upd_alt_taken;
    // Lowest-numbered free candidate wins the allocation.
    assign alloc_vec = up_free & (~up_free + NUM_TAB'(1));

    tage_base_table #(.IW(BASE_IW)) u_base (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (req_pc[PC_LSB +: BASE_IW]),
        .rd_dir (base_dir),
        .wr_idx (upd_pc[PC_LSB +: BASE_IW]),
        .ctr_en (upd_valid && upd_provider == '0),
        .taken  (upd_taken)
    );

    for (genvar t = 0; t < NUM_TAB; t++) begin : g_tab
        logic [TAB_IW-1:0] lk_idx, up_idx;
        logic [TAG_W-1:0]  lk_tag, up_tag;

        tage_hash #(.PC_W(PC_W), .PC_LSB(PC_LSB), .HIST_W(HIST_W),
                    .LEN(HIST_LEN[t]), .IW(TAB_IW), .TW(TAG_W)) u_lk_hash (
            .pc(req_pc), .ghist(ghist_q), .idx(lk_idx), .tag(lk_tag));

        tage_hash #(.PC_W(PC_W), .PC_LSB(PC_LSB), .HIST_W(HIST_W),
                    .LEN(HIST_LEN[t]), .IW(TAB_IW), .TW(TAG_W)) u_up_hash (
            .pc(upd_pc), .ghist(ghist_q), .idx(up_idx), .tag(up_tag));

        assign ctr_en[t]  = upd_valid && (upd_provider == PROV_W'(t + 1));
        assign cand[t]    = mispred && (PROV_W'(t + 1) > upd_provider);
        assign up_free[t] = cand[t] && (up_u[t] == 2'b00);
        assign u_inc[t]   = ctr_en[t] && differ && (upd_taken == upd_pred_taken);
        assign u_dec[t]   = (ctr_en[t] && differ && (upd_taken != upd_pred_taken))
                          || (cand[t] && (up_free == '0));

        tage_tagged_table #(.IW(TAB_IW), .TW(TAG_W)) u_table (
            .clk    (clk),
            .rst_n  (rst_n),
            .rd_idx (lk_idx),
            .rd_tag (lk_tag),
            .rd_hit (lk_hit[t]),
            .rd_dir (lk_dir[t]),
            .wr_idx (up_idx),
            .wr_tag (up_tag),
            .wr_u   (up_u[t]),
            .ctr_en (ctr_en[t]),
            .taken  (upd_taken),
            .u_inc  (u_inc[t]),
            .u_dec  (u_dec[t]),
            .alloc  (alloc_vec[t])
        );
    end

    // Longest hit provides; the guess it displaces becomes the alternate.
    always_comb begin
        sel_prov = '0;
        sel_dir  = base_dir;
        sel_alt  = base_dir;
        for (int t = 0; t < NUM_TAB; t++) begin
            if (lk_hit[t]) begin
                sel_alt  = sel_dir;
                sel_dir  = lk_dir[t];
                sel_prov = PROV_W'(t + 1);
            end
        end
    end

    // Register the lookup result one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pred_valid     <= 1'b0;
            pred_taken     <= 1'b0;
            pred_provider  <= '0;
            pred_alt_taken <= 1'b0;
        end else begin
            pred_valid <= req_valid;
            if (req_valid) begin
                pred_taken     <= sel_dir;
                pred_provider  <= sel_prov;
                pred_alt_taken <= sel_alt;
            end
        end
    end

    // Shift each resolved outcome into the global history.
    always_ff @(posedge clk) begin
        if (!rst_n)         ghist_q <= '0;
        else if (upd_valid) ghist_q <= {ghist_q[HIST_W-2:0], upd_taken};
    end

    assert_pred_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> pred_valid);
    assert_pred_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !pred_valid);
    assert_hist_shift_R6: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |=> (ghist_q[0] == $past(upd_taken)
                       && ghist_q[HIST_W-1:1] == $past(ghist_q[HIST_W-2:0])));
    assert_alloc_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(alloc_vec));
    assert_no_alloc_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (!mispred || upd_provider == PROV_W'(NUM_TAB)) |-> alloc_vec == '0);
endmodule

// File: tb/tage_predictor_tb.sv
// Bench: behavioural reference model (plain arrays, chunked hash) compared
// with every lookup result; pred_valid is compared every cycle.
module tage_predictor_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_pc = '0;
    logic        pred_valid, pred_taken, pred_alt_taken;
    logic [2:0]  pred_provider;
    logic        upd_valid = 1'b0;
    logic [31:0] upd_pc = '0;
    logic        upd_taken = 1'b0, upd_pred_taken = 1'b0, upd_alt_taken = 1'b0;
    logic [2:0]  upd_provider = '0;

    int    checks = 0;
    int    errors = 0;
    int    cycles = 0;
    string phase  = "R1";
    logic  prev_req = 1'b0;
    bit    done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tage_predictor u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_pc(req_pc),
        .pred_valid(pred_valid), .pred_taken(pred_taken),
        .pred_provider(pred_provider), .pred_alt_taken(pred_alt_taken),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
        .upd_pred_taken(upd_pred_taken), .upd_provider(upd_provider),
        .upd_alt_taken(upd_alt_taken)
    );

    // ---------------- reference model ----------------
    bit [1:0]  m_base [64];
    bit        m_val  [4][32];
    bit [7:0]  m_tag  [4][32];
    bit [1:0]  m_ctr  [4][32];
    bit [1:0]  m_u    [4][32];
    bit [70:0] m_hist;
    int        lens [4] = '{5, 13, 30, 71};

    function automatic int fold(bit [70:0] h, int len, int w);
        bit [127:0] m = {57'b0, h};
        int r = 0;
        m = m & ((128'd1 << len) - 128'd1);
        for (int k = 0; k * w < len; k++)
            r = r ^ int'((m >> (k * w)) & ((128'd1 << w) - 128'd1));
        return r;
    endfunction

    function automatic int m_idx(int t, bit [31:0] pc);
        return int'((pc >> 2) & 32'd31) ^ fold(m_hist, lens[t], 5);
    endfunction

    function automatic int m_tagv(int t, bit [31:0] pc);
        return int'((pc >> 7) & 32'd255) ^ fold(m_hist, lens[t], 8);
    endfunction

    function automatic bit [1:0] step(bit [1:0] c, bit up);
        if (up) return (c == 3) ? c : c + 1;
        return (c == 0) ? c : c - 1;
    endfunction

    task automatic m_reset();
        for (int i = 0; i < 64; i++) m_base[i] = 2'b01;
        for (int t = 0; t < 4; t++)
            for (int i = 0; i < 32; i++) begin
                m_val[t][i] = 0; m_tag[t][i] = 0; m_ctr[t][i] = 1; m_u[t][i] = 0;
            end
        m_hist = '0;
    endtask

    task automatic m_predict(bit [31:0] pc, output bit dir, output int prov, output bit alt);
        bit cur = m_base[(pc >> 2) & 63][1];
        dir = cur; alt = cur; prov = 0;
        for (int t = 0; t < 4; t++) begin
            int ix = m_idx(t, pc);
            if (m_val[t][ix] && m_tag[t][ix] == 8'(m_tagv(t, pc))) begin
                alt = dir; dir = m_ctr[t][ix][1]; prov = t + 1;
            end
        end
    endtask

    task automatic m_update(bit [31:0] pc, bit tk, bit pt, int prov, bit alt);
        int ix [4];
        int tg [4];
        int first = -1;
        for (int t = 0; t < 4; t++) begin ix[t] = m_idx(t, pc); tg[t] = m_tagv(t, pc); end
        if (prov == 0) m_base[(pc >> 2) & 63] = step(m_base[(pc >> 2) & 63], tk);
        else begin
            m_ctr[prov-1][ix[prov-1]] = step(m_ctr[prov-1][ix[prov-1]], tk);
            if (pt != alt) begin
                if (pt == tk && m_u[prov-1][ix[prov-1]] != 3) m_u[prov-1][ix[prov-1]]++;
                else if (pt != tk && m_u[prov-1][ix[prov-1]] != 0) m_u[prov-1][ix[prov-1]]--;
            end
        end
        if (pt != tk && prov < 4) begin
            for (int t = prov; t < 4; t++)
                if (first < 0 && m_u[t][ix[t]] == 0) first = t;
            if (first >= 0) begin
                m_val[first][ix[first]] = 1;
                m_tag[first][ix[first]] = 8'(tg[first]);
                m_ctr[first][ix[first]] = tk ? 2'b10 : 2'b01;
                m_u[first][ix[first]]   = 0;
            end else begin
                for (int t = prov; t < 4; t++)
                    if (m_u[t][ix[t]] != 0) m_u[t][ix[t]]--;
            end
        end
        m_hist = {m_hist[69:0], tk};
    endtask

    // ---------------- checking ----------------
    task automatic chk(string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", phase, what, act, exp);
        end
    endtask

    always @(posedge clk) prev_req <= req_valid;

    // R2: pred_valid follows req_valid by one cycle, checked every clock.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (pred_valid !== prev_req) begin
                errors++;
                $display("FAIL R2 pred_valid actual=%0d expected=%0d", pred_valid, prev_req);
            end
        end
    end

    task automatic branch(bit [31:0] pc, bit tk);
        bit ep, ea;
        int eprov;
        @(negedge clk);
        req_valid = 1'b1; req_pc = pc;
        m_predict(pc, ep, eprov, ea);
        @(negedge clk);
        req_valid = 1'b0;
        chk("pred_taken", int'(pred_taken), int'(ep));
        chk("pred_provider", int'(pred_provider), eprov);
        chk("pred_alt_taken", int'(pred_alt_taken), int'(ea));
        upd_valid = 1'b1; upd_pc = pc; upd_taken = tk;
        upd_pred_taken = ep; upd_provider = 3'(eprov); upd_alt_taken = ea;
        @(negedge clk);
        upd_valid = 1'b0;
        m_update(pc, tk, ep, eprov, ea);
    endtask

    initial begin
        bit [15:0] lfsr = 16'hACE1;
        m_reset();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: fresh state predicts not-taken from the base table.
        phase = "R1";
        @(negedge clk);
        chk("pred_valid_after_reset", int'(pred_valid), 0);
        branch(32'h0000_0040, 1'b0);

        // R3/R4: biased branch, saturation and two-step flip.
        phase = "R3/R4";
        for (int i = 0; i < 6; i++) branch(32'h0000_0080, 1'b1);
        for (int i = 0; i < 4; i++) branch(32'h0000_0080, 1'b0);

        // R5/R9: two addresses sharing base entry 1, different tags.
        phase = "R5/R9";
        for (int i = 0; i < 12; i++) begin
            branch(32'h0000_0004, 1'b1);
            branch(32'h0000_0104, 1'b0);
        end

        // R6/R7/R8: alternating outcome, learnable only through history.
        phase = "R6/R7/R8";
        for (int i = 0; i < 80; i++) branch(32'h0000_0200, i[0]);

        // R10/R11: period-seven loop branch.
        phase = "R10/R11";
        for (int i = 0; i < 140; i++) branch(32'h0000_1a3c, (i % 7) != 6);

        // R12/R13: pseudo-random mix over eight addresses.
        phase = "R12/R13";
        for (int i = 0; i < 900; i++) begin
            bit [31:0] pc;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            pc = 32'h0000_3000 + {25'd0, lfsr[2:0], 4'd0} + {16'd0, lfsr[2:0], 13'd0};
            branch(pc, lfsr[7] | (lfsr[2:0] == 3'd5));
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, WATCHDOG);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule